// File: doc/BRIEF.md
# Dynamic VID Reference Stepper

This block changes a regulator's reference target while the regulator runs. A 5-bit voltage-identification (VID) code comes in on a bus. The block looks at that bus only when the phase-1 switching-cycle start strobe is high. A new code becomes the target only after it has held the same value at two consecutive strobes. The block then walks the reference code one unit (25 mV) at a time toward the target. The first step waits one switching cycle, and after that there is one step every two switching cycles.

The reference code is an index in 25 mV units. It drives an external DAC and voltage lookup, which are not part of this block. All-ones is a reserved code that means no load, so it never becomes a target. With the run enable low there is no ramp: the reference takes the qualified code at once. A done flag shows when the reference has reached the target.

Top module: `vid_ref_stepper`

## Requirements
- R1: The VID bus is sampled only on clock edges where `cycleStart` is high. Values present only between strobes have no effect on `refCode` or `rampDone`.
- R2: A code is accepted as the new target at the second consecutive strobe that sees the same value. A value seen at only one strobe is never accepted.
- R3: Code 5'b11111 (all ones) never becomes the target. Holding it leaves `refCode` and `rampDone` unchanged.
- R4: With `runEn` high, there is no step at the first strobe after the acceptance strobe. The reference changes at the second strobe after acceptance, and then at every second strobe.
- R5: Each step changes `refCode` by exactly one. The step is upward when the reference is below the target and downward when it is above.
- R6: A code accepted during a ramp becomes the new target. Stepping continues from the present `refCode` with no jump, and the pacing of R4 restarts from that acceptance.
- R7: `rampDone` is high exactly when `refCode` equals the current target.
- R8: With `runEn` low, `refCode` is loaded with the accepted code on the acceptance edge. If `runEn` falls mid-ramp, `refCode` snaps to the target on the next clock.
- R9: After reset, `refCode`, the target and the last sampled code are all zero, and `rampDone` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycleStart | input | 1 | One-clock strobe at the start of each phase-1 switching cycle |
| runEn | input | 1 | High: ramp in steps; low: load the reference directly |
| vidCode | input | 5 | Requested VID code |
| refCode | output | 5 | Reference code in 25 mV units |
| rampDone | output | 1 | Reference equals target |

## Verification
The bench toggles the VID bus between strobes. A design that samples on every clock would then pick up a false target. It presents a code for one strobe only, which would catch a design that skips the stability check. It also holds the reserved all-ones code, which a careless design would start ramping toward. The bench checks the reference strobe by strobe in both directions to find a missing one-cycle wait or a pace of one step per cycle. It also retargets mid-ramp to expose a jump or a stale target, and drops the run enable mid-ramp to check that the reference snaps to the target.

// File: rtl/vid_step_pkg.sv
package vid_step_pkg;
  typedef struct packed {
    logic accept;
    logic loadDirect;
    logic stepUp;
    logic stepDown;
  } stepCtl_t;
endpackage

// File: rtl/vid_step_ctrl.sv
module vid_step_ctrl
  import vid_step_pkg::*;
#(
  parameter int VID_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStart,
  input  logic             runEn,
  input  logic [VID_W-1:0] vidCode,
  input  logic             refBelow,
  input  logic             refAbove,
  output stepCtl_t         ctl,
  output logic [VID_W-1:0] candCode
);
  localparam logic [VID_W-1:0] RESERVED = {VID_W{1'b1}};

  logic [VID_W-1:0] lastSample;
  logic             pend;
  logic             pace;
  logic             changed;
  logic             qualify;
  logic             moving;

  always_comb begin
    changed = (vidCode != lastSample);
    qualify = cycleStart && !changed && pend && (vidCode != RESERVED);
    moving  = runEn && cycleStart && !qualify && (refBelow || refAbove) && pace;
    ctl.accept     = qualify;
    ctl.loadDirect = qualify && !runEn;
    ctl.stepUp     = moving && refBelow;
    ctl.stepDown   = moving && refAbove;
  end

  assign candCode = lastSample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSample <= '0;
      pend       <= 1'b0;
      pace       <= 1'b0;
    end else begin
      if (cycleStart) begin
        if (changed) begin
          lastSample <= vidCode;
          pend       <= 1'b1;
        end else begin
          pend <= 1'b0;
        end
      end
      if (qualify) begin
        pace <= 1'b0;
      end else if (cycleStart && runEn && (refBelow || refAbove)) begin
        pace <= ~pace;
      end
    end
  end

  AST_SAMPLE_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStart |=> ($stable(lastSample) && $stable(pend))); // R1
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.accept, ctl.stepUp, ctl.stepDown})); // R4
  AST_WAIT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (qualify && runEn) |=> !(ctl.stepUp || ctl.stepDown)); // R4
endmodule

// File: rtl/vid_step_datapath.sv
module vid_step_datapath
  import vid_step_pkg::*;
#(
  parameter int VID_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  stepCtl_t         ctl,
  input  logic [VID_W-1:0] candCode,
  output logic [VID_W-1:0] refCode,
  output logic             refBelow,
  output logic             refAbove,
  output logic             done
);
  localparam logic [VID_W-1:0] RESERVED = {VID_W{1'b1}};
  localparam logic [VID_W-1:0] ONE      = VID_W'(1);

  logic [VID_W-1:0] targetCode;

  assign refBelow = refCode < targetCode;
  assign refAbove = refCode > targetCode;
  assign done     = !refBelow && !refAbove;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetCode <= '0;
      refCode    <= '0;
    end else begin
      if (ctl.accept) targetCode <= candCode;
      if (ctl.loadDirect)    refCode <= candCode;
      else if (ctl.stepUp)   refCode <= refCode + ONE;
      else if (ctl.stepDown) refCode <= refCode - ONE;
      else if (!runEn)       refCode <= targetCode;
    end
  end

  AST_NO_RESERVED_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    targetCode != RESERVED); // R3
  AST_STEP_TOWARD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runEn) && refCode != $past(refCode)) |->
      ((refCode == VID_W'($past(refCode) + ONE) && $past(refCode) < $past(targetCode)) ||
       (refCode == VID_W'($past(refCode) - ONE) && $past(refCode) > $past(targetCode)))); // R5
endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper
  import vid_step_pkg::*;
#(
  parameter int VID_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStart,
  input  logic             runEn,
  input  logic [VID_W-1:0] vidCode,
  output logic [VID_W-1:0] refCode,
  output logic             rampDone
);
  stepCtl_t         ctl;
  logic [VID_W-1:0] candCode;
  logic             refBelow;
  logic             refAbove;

  vid_step_ctrl #(.VID_W(VID_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .runEn(runEn),
    .vidCode(vidCode), .refBelow(refBelow), .refAbove(refAbove),
    .ctl(ctl), .candCode(candCode)
  );

  vid_step_datapath #(.VID_W(VID_W)) uPath (
    .clk(clk), .rstN(rstN), .runEn(runEn), .ctl(ctl), .candCode(candCode),
    .refCode(refCode), .refBelow(refBelow), .refAbove(refAbove), .done(rampDone)
  );

  AST_DONE_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cycleStart && runEn && rampDone) |=> rampDone); // R7
endmodule

// File: tb/vid_ref_stepper_test.sv
module vid_ref_stepper_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleStart = 1'b0;
  logic       runEn = 1'b1;
  logic [4:0] vidCode = 5'd0;
  logic [4:0] refCode;
  logic       rampDone;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  vid_ref_stepper uut (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .runEn(runEn),
    .vidCode(vidCode), .refCode(refCode), .rampDone(rampDone)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
  endtask

  task automatic expectRef(input string req, input int r, input int d);
    check({req, " ref"}, refCode, r);
    check({req, " done"}, rampDone, d);
  endtask

  task automatic testReset();
    expectRef("R9", 0, 1);
  endtask

  task automatic testRampUp();
    vidCode = 5'd3;
    strobe(); expectRef("R2", 0, 1);
    strobe(); expectRef("R2", 0, 0);
    strobe(); expectRef("R4", 0, 0);
    strobe(); expectRef("R4", 1, 0);
    strobe(); expectRef("R4", 1, 0);
    strobe(); expectRef("R5", 2, 0);
    strobe(); expectRef("R5", 2, 0);
    strobe(); expectRef("R7", 3, 1);
  endtask

  task automatic testSampleOnly();
    @(negedge clk); vidCode = 5'd12;
    repeat (3) @(negedge clk);
    vidCode = 5'd3;
    expectRef("R1", 3, 1);
    strobe(); strobe();
    expectRef("R1", 3, 1);
  endtask

  task automatic testGlitch();
    vidCode = 5'd7;
    strobe(); expectRef("R2", 3, 1);
    vidCode = 5'd3;
    strobe(); expectRef("R2", 3, 1);
    strobe(); strobe();
    expectRef("R2", 3, 1);
  endtask

  task automatic testReserved();
    vidCode = 5'd31;
    for (int i = 0; i < 3; i++) begin
      strobe(); expectRef("R3", 3, 1);
    end
    vidCode = 5'd3;
    strobe(); strobe();
    expectRef("R3", 3, 1);
  endtask

  task automatic testRampDown();
    vidCode = 5'd1;
    strobe(); strobe(); expectRef("R2", 3, 0);
    strobe(); expectRef("R4", 3, 0);
    strobe(); expectRef("R5", 2, 0);
    strobe(); expectRef("R5", 2, 0);
    strobe(); expectRef("R5", 1, 1);
  endtask

  task automatic testRetarget();
    vidCode = 5'd9;
    strobe(); strobe(); strobe();
    strobe(); expectRef("R6", 2, 0);
    strobe();
    strobe(); expectRef("R6", 3, 0);
    vidCode = 5'd4;
    strobe(); expectRef("R6", 3, 0);
    strobe(); expectRef("R6", 3, 0);
    strobe(); expectRef("R6", 3, 0);
    strobe(); expectRef("R6", 4, 1);
  endtask

  task automatic testDirectLoad();
    runEn = 1'b0;
    vidCode = 5'd20;
    strobe(); expectRef("R8", 4, 1);
    strobe(); expectRef("R8", 20, 1);
    runEn = 1'b1;
    vidCode = 5'd10;
    strobe(); strobe(); expectRef("R8", 20, 0);
    strobe(); strobe(); expectRef("R8", 19, 0);
    @(negedge clk); runEn = 1'b0;
    @(negedge clk); expectRef("R8", 10, 1);
    runEn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRampUp();
    testSampleOnly();
    testGlitch();
    testReserved();
    testRampDown();
    testRetarget();
    testDirectLoad();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule